// File: doc/BRIEF.md
# I2C Framed Register Read Target

This block is an I2C target that serves framed register reads. A controller opens a frame with a start, sends the target address with the write bit, and then sends a 24-bit control word. The control word carries a read flag, a length code, a checksum enable and a 20-bit register address. The controller then begins the data phase in one of two ways: a repeated start, or a stop followed by a new start. It sends the target address with the read bit, and the block returns 2, 4 or 8 data bytes. The block can add one checksum byte after the data.

Register data comes from a synchronous read port: a one-cycle request carries an address, and the 32-bit word is expected on the following cycle. An 8-byte read uses two such requests. The first is at the control-word address and the second is at that address plus two, sent while the fourth byte is still on the wire.

The bus is sampled through a two-stage synchronizer in a system clock at least sixteen times faster than SCL. SDA is modelled as an open-drain pin with separate input, output and output-enable signals.

Top module: `i2c_frame_reader`

## Requirements
- R1: A first byte after start equal to the target address with R/W = 0 is acknowledged. A first byte that matches neither address form is not acknowledged, and no byte after it is acknowledged until the next start.
- R2: After an acknowledged write address, three control bytes are each acknowledged. They arrive most significant first and form a 24-bit control word: bit 23 = read flag, bit 22 = checksum enable, bits 21:20 = length code, bits 19:0 = register address.
- R3: The target address with R/W = 1 is acknowledged only if a complete control word with bit 23 set came before it. The read address may follow either a repeated start or a stop and a new start. Each control word permits one read; the read address is refused in every other case.
- R4: The number of data bytes follows the length code: 00 gives 2, 01 gives 4, 10 gives 8, and 11 gives 4. After the last byte (or after the checksum byte, when it is enabled), SDA stays released even if the controller acknowledges.
- R5: Each 32-bit word goes out least significant byte first, and each byte goes out most significant bit first.
- R6: The register port raises its request for exactly one cycle and takes the data on the next cycle. An 8-byte read returns the word at the control-word address, then the word at that address plus 2, modulo 2^20.
- R7: When bit 22 is set, one extra byte follows the data. It is a CRC-8 (polynomial 0x07, initial value 0xFF, MSB first, no final XOR) computed over: the write address byte, the three control bytes, the read address byte, and all data bytes sent.
- R8: A not-acknowledge from the controller on any transmitted byte ends the transfer. SDA then stays released until the next start. While idle, SDA is never driven.
- R9: A start or stop at any point aborts the current byte sequence. A control word cut short by a start or stop does not permit a read.
- R10: SDA is released in the acknowledge slot after every transmitted byte. The output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_o | output | 1 | Serial data output value, always 0 (open drain) |
| sda_oe | output | 1 | High pulls SDA low |
| reg_rd_en | output | 1 | One-cycle register read request |
| reg_rd_addr | output | 20 | Register address for the request |
| reg_rd_data | input | 32 | Register word, valid the cycle after the request |

## Verification
The checks take for granted that the controller moves SDA only while SCL is low, except for start and stop conditions. They also assume each SCL phase lasts well beyond the synchronizer and edge-detect latency, and that register data arrives one cycle after each request. The stimulus respects all three. The bench controller changes lines only at quarter-period points five system cycles apart, always while SCL is low except for start and stop, and its register model answers with a registered lookup. Because the block never drives SDA during a start or stop, the rule that the output enable changes only while SCL is low holds under these conditions.

// File: rtl/i2c_frame_pkg.sv
package i2c_frame_pkg;

    localparam int CW_W    = 24;
    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } fr_state_e;

    typedef enum logic [1:0] {
        PH_ID,
        PH_C0,
        PH_C1,
        PH_C2
    } fr_phase_e;

    typedef enum logic [1:0] {
        AK_MORE_CTRL,
        AK_CTRL_DONE,
        AK_START_TX
    } fr_ackgo_e;

    // Data bytes for each length code; the reserved code behaves as 4 bytes.
    function automatic logic [CNT_W-1:0] data_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return CNT_W'(2);
            2'b10:   return CNT_W'(8);
            default: return CNT_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic              scl_prev_q, sda_prev_q;
    logic              scl_now, sda_now;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh_q <= '1;
                    sda_sh_q <= '1;
                end else begin
                    scl_sh_q <= scl_i;
                    sda_sh_q <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh_q <= '1;
                    sda_sh_q <= '1;
                end else begin
                    scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
                    sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_now = scl_sh_q[STAGES-1];
    assign sda_now = sda_sh_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_now;
            sda_prev_q <= sda_now;
        end
    end

    assign sda_lvl   = sda_now;
    assign scl_rise  = scl_now & ~scl_prev_q;
    assign scl_fall  = ~scl_now & scl_prev_q;
    assign start_det = scl_now & scl_prev_q & sda_prev_q & ~sda_now;
    assign stop_det  = scl_now & scl_prev_q & ~sda_prev_q & sda_now;

endmodule

// File: rtl/frame_crc8.sv
module frame_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] byte_in,
    output logic [7:0] crc_out
);
    always_comb begin
        logic [7:0] c;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            if (c[7] ^ byte_in[i]) c = {c[6:0], 1'b0} ^ POLY;
            else                   c = {c[6:0], 1'b0};
        end
        crc_out = c;
    end
endmodule

// File: rtl/i2c_frame_reader.sv
module i2c_frame_reader
    import i2c_frame_pkg::*;
#(
    parameter logic [6:0] TARGET_ID   = 7'h45,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rd_data
);
    localparam logic [7:0] ID_WR = {TARGET_ID, 1'b0};
    localparam logic [7:0] ID_RD = {TARGET_ID, 1'b1};

    typedef struct packed {
        fr_state_e          state;
        fr_phase_e          phase;
        fr_ackgo_e          ackgo;
        logic [CNT_W-1:0]   bitcnt;
        logic [7:0]         shreg;
        logic [CW_W-1:0]    ctrl;
        logic               ctrl_ok;
        logic [7:0]         crc;
        logic [CNT_W-1:0]   bidx;
        logic               tx_crc;
        logic               ack;
        logic [DATA_W-1:0]  word;
        logic               rd_en;
        logic               rd_pend;
        logic [ADDR_W-1:0]  rd_addr;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // CRC operand selection: received byte in RX, next outgoing data byte otherwise.
    logic [CNT_W-1:0] load_idx_d;
    logic [7:0]       word_byte_d;
    logic [7:0]       crc_in_d, crc_byte_d, crc_out_d;
    logic [CNT_W-1:0] total_d;

    always_comb begin
        load_idx_d  = (cur_q.state == ST_ACK) ? '0 : cur_q.bidx + CNT_W'(1);
        word_byte_d = 8'(cur_q.word >> {load_idx_d[1:0], 3'b000});
        total_d     = data_bytes(cur_q.ctrl[21:20]);
        if (cur_q.state == ST_RX) begin
            crc_byte_d = cur_q.shreg;
            crc_in_d   = (cur_q.phase == PH_ID && !cur_q.shreg[0]) ? 8'hFF : cur_q.crc;
        end else begin
            crc_byte_d = word_byte_d;
            crc_in_d   = cur_q.crc;
        end
    end

    frame_crc8 #(.POLY(8'h07)) u_crc (
        .crc_in  (crc_in_d),
        .byte_in (crc_byte_d),
        .crc_out (crc_out_d)
    );

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.rd_en   = 1'b0;
        nxt_d.rd_pend = cur_q.rd_en;
        if (cur_q.rd_pend) nxt_d.word = reg_rd_data;

        if (start_det) begin
            nxt_d.state  = ST_RX;
            nxt_d.phase  = PH_ID;
            nxt_d.bitcnt = '0;
        end else if (stop_det) begin
            nxt_d.state = ST_IDLE;
        end else begin
            unique case (cur_q.state)
                ST_RX: begin
                    if (scl_rise && cur_q.bitcnt < CNT_W'(8)) begin
                        nxt_d.shreg  = {cur_q.shreg[6:0], sda_lvl};
                        nxt_d.bitcnt = cur_q.bitcnt + CNT_W'(1);
                    end else if (scl_fall && cur_q.bitcnt == CNT_W'(8)) begin
                        unique case (cur_q.phase)
                            PH_ID: begin
                                if (cur_q.shreg == ID_WR) begin
                                    nxt_d.ctrl_ok = 1'b0;
                                    nxt_d.crc     = crc_out_d;
                                    nxt_d.state   = ST_ACK;
                                    nxt_d.ackgo   = AK_MORE_CTRL;
                                    nxt_d.phase   = PH_C0;
                                end else if (cur_q.shreg == ID_RD && cur_q.ctrl_ok
                                             && cur_q.ctrl[23]) begin
                                    nxt_d.ctrl_ok = 1'b0;
                                    nxt_d.crc     = crc_out_d;
                                    nxt_d.state   = ST_ACK;
                                    nxt_d.ackgo   = AK_START_TX;
                                    nxt_d.rd_en   = 1'b1;
                                    nxt_d.rd_addr = cur_q.ctrl[ADDR_W-1:0];
                                end else begin
                                    nxt_d.state = ST_IDLE;
                                end
                            end
                            PH_C0, PH_C1: begin
                                nxt_d.ctrl  = {cur_q.ctrl[15:0], cur_q.shreg};
                                nxt_d.crc   = crc_out_d;
                                nxt_d.state = ST_ACK;
                                nxt_d.ackgo = AK_MORE_CTRL;
                                nxt_d.phase = (cur_q.phase == PH_C0) ? PH_C1 : PH_C2;
                            end
                            default: begin
                                nxt_d.ctrl    = {cur_q.ctrl[15:0], cur_q.shreg};
                                nxt_d.ctrl_ok = 1'b1;
                                nxt_d.crc     = crc_out_d;
                                nxt_d.state   = ST_ACK;
                                nxt_d.ackgo   = AK_CTRL_DONE;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        unique case (cur_q.ackgo)
                            AK_MORE_CTRL: begin
                                nxt_d.state  = ST_RX;
                                nxt_d.bitcnt = '0;
                            end
                            AK_START_TX: begin
                                nxt_d.state  = ST_TX;
                                nxt_d.shreg  = word_byte_d;
                                nxt_d.crc    = crc_out_d;
                                nxt_d.bidx   = '0;
                                nxt_d.tx_crc = 1'b0;
                                nxt_d.bitcnt = '0;
                            end
                            default: nxt_d.state = ST_IDLE;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cur_q.bitcnt == CNT_W'(7)) begin
                            nxt_d.state = ST_RACK;
                            nxt_d.ack   = 1'b0;
                        end else begin
                            nxt_d.shreg  = {cur_q.shreg[6:0], 1'b1};
                            nxt_d.bitcnt = cur_q.bitcnt + CNT_W'(1);
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        nxt_d.ack = ~sda_lvl;
                    end else if (scl_fall) begin
                        nxt_d.bitcnt = '0;
                        if (!cur_q.ack || cur_q.tx_crc) begin
                            nxt_d.state = ST_IDLE;
                        end else if (load_idx_d < total_d) begin
                            nxt_d.state = ST_TX;
                            nxt_d.shreg = word_byte_d;
                            nxt_d.crc   = crc_out_d;
                            nxt_d.bidx  = load_idx_d;
                            if (load_idx_d == CNT_W'(3) && cur_q.ctrl[21:20] == 2'b10) begin
                                nxt_d.rd_en   = 1'b1;
                                nxt_d.rd_addr = cur_q.ctrl[ADDR_W-1:0] + ADDR_W'(2);
                            end
                        end else if (cur_q.ctrl[22]) begin
                            nxt_d.state  = ST_TX;
                            nxt_d.shreg  = cur_q.crc;
                            nxt_d.tx_crc = 1'b1;
                        end else begin
                            nxt_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q         <= '0;
            cur_q.state   <= ST_IDLE;
            cur_q.phase   <= PH_ID;
            cur_q.ackgo   <= AK_MORE_CTRL;
            cur_q.shreg   <= 8'hFF;
            cur_q.crc     <= 8'hFF;
        end else begin
            cur_q <= nxt_d;
        end
    end

    fr_state_e state_q;
    assign state_q     = cur_q.state;
    assign sda_o       = 1'b0;
    assign sda_oe      = (cur_q.state == ST_ACK) || (cur_q.state == ST_TX && !cur_q.shreg[7]);
    assign reg_rd_en   = cur_q.rd_en;
    assign reg_rd_addr = cur_q.rd_addr;

endmodule

// File: rtl/i2c_frame_reader_chk.sv
module i2c_frame_reader_chk
    import i2c_frame_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_i,
    input logic      sda_oe,
    input logic      rd_en,
    input fr_state_e state
);
    // R10: the pull-down only toggles in the SCL low phase
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R10: SDA is driven only in an acknowledge slot or a transmitted bit
    assert_oe_in_drive_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ACK || state == ST_TX));

    // R8: nothing is driven while idle
    assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R6: register requests are single-cycle pulses
    assert_rd_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    // R6: requests only accompany an accepted read or a transmitted byte
    assert_rd_when_serving_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (state == ST_ACK || state == ST_TX));
endmodule

bind i2c_frame_reader i2c_frame_reader_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_oe (sda_oe),
    .rd_en  (reg_rd_en),
    .state  (state_q)
);

// File: tb/i2c_frame_reader_bench.sv
`timescale 1ns/1ps
module i2c_frame_reader_bench;
    localparam logic [6:0] ID = 7'h45;
    localparam int Q = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_bus;
    logic        sda_o, sda_oe, rd_en;
    logic [19:0] rd_addr;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~(sda_oe & ~sda_o);

    i2c_frame_reader #(.TARGET_ID(ID)) u_i2c_frame_reader (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_o(sda_o), .sda_oe(sda_oe), .reg_rd_en(rd_en),
        .reg_rd_addr(rd_addr), .reg_rd_data(rd_data)
    );

    function automatic logic [31:0] model(input logic [19:0] a);
        return {~a[11:0], a};
    endfunction

    always_ff @(posedge clk) if (rd_en) rd_data <= model(rd_addr);

    function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) r = (r[7] ^ b[i]) ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
        end
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; ack = ~sda_bus; #Q; m_scl = 1'b0; #Q;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            #Q; m_scl = 1'b1; #Q; b = {b[6:0], sda_bus}; #Q; m_scl = 1'b0; #Q;
        end
        m_sda = ~give_ack; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q; m_sda = 1'b1;
    endtask

    // Full framed read with every byte checked, then one extra clocked byte.
    task automatic do_read(input logic [19:0] addr, input logic [1:0] code,
                           input logic crc_en, input logic via_stop);
        logic [23:0] cw;
        logic [7:0]  b, crc;
        logic        ack;
        logic [31:0] w0, w1, w;
        int          n;
        cw  = {1'b1, crc_en, code, addr};
        n   = (code == 2'b00) ? 2 : (code == 2'b10) ? 8 : 4;
        w0  = model(addr);
        w1  = model(addr + 20'd2);
        crc = crc8(8'hFF, {ID, 1'b0});
        crc = crc8(crc, cw[23:16]);
        crc = crc8(crc, cw[15:8]);
        crc = crc8(crc, cw[7:0]);
        crc = crc8(crc, {ID, 1'b1});
        bus_start();
        wr_byte({ID, 1'b0}, ack); chk("R1 write id ack", ack, 1);
        wr_byte(cw[23:16], ack);  chk("R2 ctrl byte0 ack", ack, 1);
        wr_byte(cw[15:8], ack);   chk("R2 ctrl byte1 ack", ack, 1);
        wr_byte(cw[7:0], ack);    chk("R2 ctrl byte2 ack", ack, 1);
        if (via_stop) begin
            bus_stop();
            bus_start();
        end else begin
            bus_start();
        end
        wr_byte({ID, 1'b1}, ack); chk("R3 read id ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            w = (i < 4) ? w0 : w1;
            rd_byte(1'b1, b);
            chk((i < 4) ? "R5 data byte" : "R6 second word byte", b, 8'(w >> (8 * (i % 4))));
            crc = crc8(crc, b);
        end
        if (crc_en) begin
            rd_byte(1'b1, b);
            chk("R7 crc byte", b, crc);
        end
        rd_byte(1'b0, b);
        chk("R4 no byte past end", b, 8'hFF);
        bus_stop();
        chk("R8 released after frame", sda_oe, 0);
    endtask

    initial begin
        logic        ack;
        logic [7:0]  b;
        repeat (4) @(negedge clk);
        chk("R8 reset oe", sda_oe, 0);
        chk("R6 reset rd_en", rd_en, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Wrong address: no ack, and following bytes ignored
        bus_start();
        wr_byte({ID ^ 7'h01, 1'b0}, ack); chk("R1 wrong id nack", ack, 0);
        wr_byte({ID, 1'b0}, ack);         chk("R1 ignored after mismatch", ack, 0);
        wr_byte(8'hC0, ack);              chk("R1 ignored ctrl", ack, 0);
        bus_stop();

        // Read address with no control word
        bus_start();
        wr_byte({ID, 1'b1}, ack); chk("R3 read id without ctrl", ack, 0);
        bus_stop();

        // Control word with read flag clear
        bus_start();
        wr_byte({ID, 1'b0}, ack); wr_byte(8'h10, ack); wr_byte(8'h00, ack); wr_byte(8'h04, ack);
        chk("R2 ctrl ack with write flag", ack, 1);
        bus_start();
        wr_byte({ID, 1'b1}, ack); chk("R3 read id after write-flag ctrl", ack, 0);
        bus_stop();

        // Control word cut by stop
        bus_start();
        wr_byte({ID, 1'b0}, ack); wr_byte(8'h90, ack);
        bus_stop();
        bus_start();
        wr_byte({ID, 1'b1}, ack); chk("R9 read id after stop-cut ctrl", ack, 0);
        bus_stop();

        // Control word cut by repeated start
        bus_start();
        wr_byte({ID, 1'b0}, ack); wr_byte(8'h90, ack); wr_byte(8'h00, ack);
        bus_start();
        wr_byte({ID, 1'b1}, ack); chk("R9 read id after start-cut ctrl", ack, 0);
        bus_stop();

        // Sweep: length codes, checksum, restart kind, two addresses (one wraps)
        for (int a = 0; a < 2; a++)
            for (int c = 0; c < 4; c++)
                for (int e = 0; e < 2; e++)
                    for (int s = 0; s < 2; s++)
                        do_read((a == 0) ? 20'h00130 : 20'hFFFFE, 2'(c), 1'(e), 1'(s));

        // One read per control word
        bus_start();
        wr_byte({ID, 1'b1}, ack); chk("R3 second read refused", ack, 0);
        bus_stop();

        // Controller not-acknowledge mid-frame
        bus_start();
        wr_byte({ID, 1'b0}, ack); wr_byte(8'hE0, ack); wr_byte(8'h05, ack); wr_byte(8'h50, ack);
        bus_start();
        wr_byte({ID, 1'b1}, ack); chk("R3 read id ack before nack test", ack, 1);
        rd_byte(1'b1, b); chk("R5 byte0 before nack", b, 8'(model(20'h00550)));
        rd_byte(1'b0, b); chk("R5 byte1 before nack", b, 8'(model(20'h00550) >> 8));
        rd_byte(1'b1, b); chk("R8 released after nack", b, 8'hFF);
        bus_stop();

        chk("R10 oe low at end", sda_oe, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule